// File: doc/BRIEF.md
# Four-Address Memory-to-Memory Sequencer

This block is a very small processor that has no program counter register and no data registers. Every instruction is 13 bytes in memory. It holds an operation code, two source addresses, a destination address and the address of the instruction that runs next. The sequencer reads the instruction one byte at a time. It then reads two 32-bit operands, combines them and stores the result. After that it continues at the address carried in the instruction. Nothing in the block ever increments an address to find the next instruction.

All storage sits behind a single synchronous byte port. Each request moves one byte, and read data comes back in the cycle after the request. Software places a program in memory and pulses `start_i` with the entry address. It then waits until `busy_o` falls. `done_o` reports a normal stop through the halt code. `err_o` reports an operation code the block does not know.

Top module: `quad_addr_seq`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o`, `err_o` and `mem_req_o` are all low until a start is accepted.
- R2: A start pulse taken while idle makes the block issue a read request at `start_addr_i` in the next cycle. It also clears `done_o` and `err_o`.
- R3: An instruction is 13 bytes. Byte 0 is the operation code. Bytes 1-3 hold the destination address, bytes 4-6 the first source address, bytes 7-9 the second source address and bytes 10-12 the next-instruction address. Each address field is stored least significant byte first.
- R4: Each read byte takes two cycles: a request cycle followed by a cycle without a request, in which the data is taken. Each stored byte takes one cycle. So every arithmetic instruction keeps `busy_o` high for 47 cycles, and the final halting or faulting instruction keeps it high for 27 cycles.
- R5: Operands and results are 32-bit words held in four consecutive bytes, least significant byte at the lowest address.
- R6: Code 0x01 adds, 0x02 subtracts (first source minus second), 0x03 takes the bitwise AND and 0x04 the bitwise OR. All results are modulo 2^32.
- R7: Both source words are read completely before any byte of the result is written to the destination. Execution then continues at the next-instruction address, with no increment.
- R8: Code 0xFF makes no operand access and no write. It drops `busy_o` and raises `done_o`, and `done_o` stays high until the next start.
- R9: Any other code makes no operand access and no write. It drops `busy_o` and raises `err_o`, and `err_o` stays high until the next start.
- R10: A start pulse while `busy_o` is high has no effect on the run in progress.
- R11: Every address, including field offsets and operand bytes, is formed modulo 2^24, so an instruction or word may span from the top of memory to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| start_addr_i | input | 24 | Address of the first instruction |
| busy_o | output | 1 | A program is running |
| done_o | output | 1 | Last run ended on the halt code |
| err_o | output | 1 | Last run ended on an unknown code |
| mem_req_o | output | 1 | Byte access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 24 | Byte address of the request |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Read byte, valid the cycle after a read request |

## Verification
The hardest case to reach from the ports is a word or an instruction that spans the top of the address space, where a source overlaps the destination of the same instruction. The stimulus places an instruction just below the wrap point. Its first source and its destination straddle address 0 and share bytes, so wrap arithmetic and the order of read before write both decide the stored bytes. A second hard case is a start pulse that arrives mid-run. It is aimed at a faulting instruction, so if it were accepted it would raise the error flag. Random chains of non-sequential instructions with overlapping unaligned operands are compared byte by byte against a model in the bench, together with the exact busy cycle count.

// File: rtl/qa_pkg.sv
package qa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_SRCA,
    ST_SRCB,
    ST_STORE
  } qa_state_e;

  typedef enum logic [1:0] {
    FN_ADD,
    FN_SUB,
    FN_AND,
    FN_OR
  } qa_fn_e;

  localparam int unsigned QA_OPC_W = 8;

  localparam logic [QA_OPC_W-1:0] OPC_ADD  = 8'h01;
  localparam logic [QA_OPC_W-1:0] OPC_SUB  = 8'h02;
  localparam logic [QA_OPC_W-1:0] OPC_AND  = 8'h03;
  localparam logic [QA_OPC_W-1:0] OPC_OR   = 8'h04;
  localparam logic [QA_OPC_W-1:0] OPC_HALT = 8'hFF;

endpackage

// File: rtl/qa_ibuf.sv
// Instruction byte buffer: one enabled byte lane per instruction byte.
module qa_ibuf #(
  parameter int NB = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [$clog2(NB)-1:0] wr_idx,
  input  logic [7:0]            wr_byte,
  output logic [NB*8-1:0]       word
);

  localparam int IW = $clog2(NB);

  generate
    for (genvar g = 0; g < NB; g++) begin : g_lane
      logic       lane_en;
      logic [7:0] lane_q;

      assign lane_en = wr_en && (wr_idx == IW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane_q <= '0;
        end else if (lane_en) begin
          lane_q <= wr_byte;
        end
      end

      assign word[g*8 +: 8] = lane_q;
    end
  endgenerate

endmodule

// File: rtl/qa_decode.sv
// Splits the fetched instruction into code and four address fields.
module qa_decode
  import qa_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [QA_OPC_W+4*AW-1:0] insn,
  output logic [AW-1:0]            dst_addr,
  output logic [AW-1:0]            srca_addr,
  output logic [AW-1:0]            srcb_addr,
  output logic [AW-1:0]            next_addr,
  output qa_fn_e                   fn,
  output logic                     is_halt,
  output logic                     is_arith
);

  logic [QA_OPC_W-1:0] opc;

  assign opc       = insn[QA_OPC_W-1:0];
  assign dst_addr  = insn[QA_OPC_W + 0*AW +: AW];
  assign srca_addr = insn[QA_OPC_W + 1*AW +: AW];
  assign srcb_addr = insn[QA_OPC_W + 2*AW +: AW];
  assign next_addr = insn[QA_OPC_W + 3*AW +: AW];

  always_comb begin
    fn       = FN_ADD;
    is_halt  = 1'b0;
    is_arith = 1'b0;
    case (opc)
      OPC_ADD:  begin fn = FN_ADD; is_arith = 1'b1; end
      OPC_SUB:  begin fn = FN_SUB; is_arith = 1'b1; end
      OPC_AND:  begin fn = FN_AND; is_arith = 1'b1; end
      OPC_OR:   begin fn = FN_OR;  is_arith = 1'b1; end
      OPC_HALT: is_halt = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/qa_alu.sv
// Word-wide combining unit.
module qa_alu
  import qa_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  qa_fn_e        fn,
  output logic [DW-1:0] y
);

  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      default: y = a | b;
    endcase
  end

endmodule

// File: rtl/quad_addr_seq.sv
module quad_addr_seq
  import qa_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i
);

  localparam int NB  = (QA_OPC_W + 4*AW) / 8;  // instruction bytes
  localparam int OB  = DW / 8;                 // operand bytes
  localparam int CW  = $clog2(NB);
  localparam int SW  = $clog2(OB);

  // ---------------- reset: asserted at once, released on the clock
  logic rst_q1, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  // ---------------- state
  qa_state_e      state, state_n;
  logic           phase, phase_n;
  logic [CW-1:0]  cnt, cnt_n;
  logic [AW-1:0]  pc, pc_n;
  logic           pc_en;
  logic [DW-1:0]  opa, opb;
  logic           opa_we, opb_we, ibuf_we;
  logic           done_q, done_n, err_q, err_n;

  // ---------------- sub-blocks
  logic [NB*8-1:0] insn;
  logic [AW-1:0]   dst_addr, srca_addr, srcb_addr, next_addr;
  qa_fn_e          fn;
  logic            is_halt, is_arith;
  logic [DW-1:0]   res;

  qa_ibuf #(.NB(NB)) i_ibuf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (ibuf_we),
    .wr_idx  (cnt),
    .wr_byte (mem_rdata_i),
    .word    (insn)
  );

  qa_decode #(.AW(AW)) i_decode (
    .insn      (insn),
    .dst_addr  (dst_addr),
    .srca_addr (srca_addr),
    .srcb_addr (srcb_addr),
    .next_addr (next_addr),
    .fn        (fn),
    .is_halt   (is_halt),
    .is_arith  (is_arith)
  );

  qa_alu #(.DW(DW)) i_alu (
    .a  (opa),
    .b  (opb),
    .fn (fn),
    .y  (res)
  );

  // ---------------- memory port
  logic [AW-1:0] base_addr;
  logic          rd_slot;

  always_comb begin
    case (state)
      ST_SRCA:  base_addr = srca_addr;
      ST_SRCB:  base_addr = srcb_addr;
      ST_STORE: base_addr = dst_addr;
      default:  base_addr = pc;
    endcase
  end

  assign rd_slot     = (state == ST_FETCH) || (state == ST_SRCA) || (state == ST_SRCB);
  assign mem_req_o   = (rd_slot && !phase) || (state == ST_STORE);
  assign mem_we_o    = (state == ST_STORE);
  assign mem_addr_o  = base_addr + AW'(cnt);
  assign mem_wdata_o = res[{cnt[SW-1:0], 3'b000} +: 8];

  assign busy_o = (state != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  // ---------------- next state
  always_comb begin
    state_n = state;
    phase_n = phase;
    cnt_n   = cnt;
    pc_n    = pc;
    pc_en   = 1'b0;
    opa_we  = 1'b0;
    opb_we  = 1'b0;
    ibuf_we = 1'b0;
    done_n  = done_q;
    err_n   = err_q;

    case (state)
      ST_IDLE: begin
        if (start_i) begin
          state_n = ST_FETCH;
          phase_n = 1'b0;
          cnt_n   = '0;
          pc_n    = start_addr_i;
          pc_en   = 1'b1;
          done_n  = 1'b0;
          err_n   = 1'b0;
        end
      end

      ST_FETCH: begin
        phase_n = !phase;
        if (phase) begin
          ibuf_we = 1'b1;
          if (cnt == CW'(NB-1)) begin
            cnt_n   = '0;
            state_n = ST_DECODE;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end

      ST_DECODE: begin
        cnt_n   = '0;
        phase_n = 1'b0;
        if (is_arith) begin
          state_n = ST_SRCA;
        end else begin
          state_n = ST_IDLE;
          done_n  = is_halt;
          err_n   = !is_halt;
        end
      end

      ST_SRCA, ST_SRCB: begin
        phase_n = !phase;
        if (phase) begin
          opa_we = (state == ST_SRCA);
          opb_we = (state == ST_SRCB);
          if (cnt == CW'(OB-1)) begin
            cnt_n   = '0;
            state_n = (state == ST_SRCA) ? ST_SRCB : ST_STORE;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end

      ST_STORE: begin
        if (cnt == CW'(OB-1)) begin
          cnt_n   = '0;
          phase_n = 1'b0;
          state_n = ST_FETCH;
          pc_n    = next_addr;
          pc_en   = 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end

      default: state_n = ST_IDLE;
    endcase
  end

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state  <= ST_IDLE;
      phase  <= 1'b0;
      cnt    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      state  <= state_n;
      phase  <= phase_n;
      cnt    <= cnt_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc <= '0;
    end else if (pc_en) begin
      pc <= pc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      opa <= '0;
      opb <= '0;
    end else begin
      if (opa_we) opa[{cnt[SW-1:0], 3'b000} +: 8] <= mem_rdata_i;
      if (opb_we) opb[{cnt[SW-1:0], 3'b000} +: 8] <= mem_rdata_i;
    end
  end

  // ---------------- assertions
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy_o |-> !mem_req_o);

  // R2
  start_fetch_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_o && start_i) |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(start_addr_i)));

  // R4
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_o && !mem_we_o) |=> !mem_req_o);

  // R4
  we_has_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we_o |-> mem_req_o);

  // R5
  store_seq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (!busy_o && !err_o));

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(err_o) |-> (!busy_o && !mem_req_o));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && start_i && mem_req_o && !mem_we_o) |=> !mem_req_o);

endmodule

// File: tb/test_quad_addr_seq.sv
module test_quad_addr_seq;

  localparam logic [23:0] POOL  = 24'h200000;
  localparam logic [23:0] HALTA = 24'h000040;
  localparam logic [23:0] BADA  = 24'h000080;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [23:0] start_addr_i;
  logic        busy_o, done_o, err_o;
  logic        mem_req_o, mem_we_o;
  logic [23:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;

  int total = 0;
  int bad   = 0;
  int wr_cnt = 0;

  logic [7:0] dm [logic [23:0]];
  logic [7:0] sm [logic [23:0]];

  quad_addr_seq i_quad_addr_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] rd_dm(input logic [23:0] a);
    return dm.exists(a) ? dm[a] : 8'h00;
  endfunction

  function automatic logic [7:0] rd_sm(input logic [23:0] a);
    return sm.exists(a) ? sm[a] : 8'h00;
  endfunction

  // synchronous byte memory
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        dm[mem_addr_o] = mem_wdata_o;
        wr_cnt = wr_cnt + 1;
      end else begin
        mem_rdata_i <= rd_dm(mem_addr_o);
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic put(input logic [23:0] a, input logic [7:0] v);
    dm[a] = v;
    sm[a] = v;
  endtask

  task automatic put_insn(input logic [23:0] a, input logic [7:0] op,
                          input logic [23:0] d, input logic [23:0] s1,
                          input logic [23:0] s2, input logic [23:0] nx);
    logic [103:0] w;
    w = {nx, s2, s1, d, op};
    for (int k = 0; k < 13; k++) put(a + 24'(k), w[k*8 +: 8]);
  endtask

  // bench reference: interprets the program held in sm
  int m_ops;
  bit m_err;

  function automatic logic [23:0] sm_field(input logic [23:0] pc, input int j);
    return {rd_sm(pc + 24'(3*j+3)), rd_sm(pc + 24'(3*j+2)), rd_sm(pc + 24'(3*j+1))};
  endfunction

  function automatic logic [31:0] sm_word(input logic [23:0] a);
    return {rd_sm(a + 24'd3), rd_sm(a + 24'd2), rd_sm(a + 24'd1), rd_sm(a)};
  endfunction

  task automatic run_model(input logic [23:0] sa);
    logic [23:0] pc;
    logic [7:0]  op;
    logic [31:0] x, y, r;
    logic [23:0] d;
    pc = sa; m_ops = 0; m_err = 0;
    for (int step = 0; step < 200; step++) begin
      op = rd_sm(pc);
      if (op == 8'hFF) break;
      if (op < 8'h01 || op > 8'h04) begin m_err = 1; break; end
      d = sm_field(pc, 0);
      x = sm_word(sm_field(pc, 1));
      y = sm_word(sm_field(pc, 2));
      case (op)
        8'h01: r = x + y;
        8'h02: r = x - y;
        8'h03: r = x & y;
        default: r = x | y;
      endcase
      for (int k = 0; k < 4; k++) sm[d + 24'(k)] = r[k*8 +: 8];
      m_ops++;
      pc = sm_field(pc, 3);
    end
  endtask

  function automatic int cmp_range(input logic [23:0] a, input int len);
    int n = 0;
    for (int k = 0; k < len; k++)
      if (rd_dm(a + 24'(k)) !== rd_sm(a + 24'(k))) n++;
    return n;
  endfunction

  // start a run, follow it to the end and check it against the model
  task automatic run_check(input string tag, input logic [23:0] sa,
                           input logic [23:0] cmp_a, input int cmp_len,
                           input bit inject);
    int cyc;
    int w0;
    run_model(sa);
    @(negedge clk);
    start_i = 1'b1;
    start_addr_i = sa;
    w0 = wr_cnt;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", {tag, " first request"}, {mem_req_o, mem_we_o, mem_addr_o}, {1'b1, 1'b0, sa});
    chk("R2", {tag, " flags cleared"}, {done_o, err_o}, 2'b00);
    cyc = 0;
    while (busy_o && cyc < 20000) begin
      cyc++;
      if (inject && cyc == 20) begin
        start_i = 1'b1;
        start_addr_i = BADA;   // R10: would fault if taken
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R4", {tag, " busy cycles"}, cyc, m_ops * 47 + 27);
    chk(m_err ? "R9" : "R8", {tag, " end flags"}, {done_o, err_o}, {!m_err, m_err});
    chk("R7", {tag, " write count"}, wr_cnt - w0, m_ops * 4);
    chk("R6", {tag, " memory image"}, cmp_range(cmp_a, cmp_len), 0);
  endtask

  task automatic gen_random(input int run, output logic [23:0] entry);
    logic [23:0] base;
    int n;
    base = 24'h100000 + 24'(run) * 24'h400;
    n = 3 + int'($urandom % 8);
    for (int k = 0; k < 80; k++) put(POOL + 24'(k), 8'($urandom));
    for (int i = 0; i < n; i++) begin
      put_insn(base + 24'(((i*7) % 16) * 16),
               8'(1 + $urandom % 4),
               POOL + 24'($urandom % 72),
               POOL + 24'($urandom % 72),
               POOL + 24'($urandom % 72),
               base + 24'((((i+1)*7) % 16) * 16));   // R3: non-sequential next
    end
    put_insn(base + 24'(((n*7) % 16) * 16), 8'hFF, '0, '0, '0, '0);
    entry = base;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R4 watchdog: got %0d exp %0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [23:0] entry;
    void'($urandom(32'd7321));
    start_i = 1'b0;
    start_addr_i = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "idle after reset", {busy_o, done_o, err_o, mem_req_o}, 4'b0000);

    put_insn(HALTA, 8'hFF, 24'h300000, 24'h300000, 24'h300000, 24'h300000);
    put_insn(BADA,  8'h07, 24'h300000, 24'h300004, 24'h300008, HALTA);
    for (int k = 0; k < 16; k++) put(24'h300000 + 24'(k), 8'($urandom));

    // R8: halt alone touches nothing
    run_check("R8 halt only", HALTA, 24'h300000, 16, 1'b0);
    // R9: unknown code, no write
    run_check("R9 unknown code", BADA, 24'h300000, 16, 1'b0);
    // R8: halt run after fault clears err
    run_check("R8 clear after fault", HALTA, 24'h300000, 16, 1'b0);

    // R11 and R7: wrap at the top of memory, destination aliases source
    put(24'hFFFFFE, 8'h81); put(24'hFFFFFF, 8'hFF); put(24'h000000, 8'h7F); put(24'h000001, 8'h12);
    put(24'h000010, 8'h90); put(24'h000011, 8'h00); put(24'h000012, 8'h81); put(24'h000013, 8'hEE);
    put_insn(24'hFFFFF0, 8'h01, 24'hFFFFFF, 24'hFFFFFE, 24'h000010, HALTA);
    run_check("R11 wrap", 24'hFFFFF0, 24'hFFFFF0, 48, 1'b0);

    // R7: sub with destination equal to first source, then or into second
    for (int k = 0; k < 8; k++) put(24'h300200 + 24'(k), 8'($urandom));
    put_insn(24'h300100, 8'h02, 24'h300200, 24'h300200, 24'h300204, 24'h300180);
    put_insn(24'h300180, 8'h04, 24'h300204, 24'h300200, 24'h300204, HALTA);
    run_check("R7 alias", 24'h300100, 24'h300200, 16, 1'b0);

    // R5 R6 R3: random non-sequential programs
    for (int run = 0; run < 16; run++) begin
      gen_random(run, entry);
      run_check("R5 random", entry, POOL, 80, 1'b0);
    end

    // R10: start pulse mid-run is ignored
    gen_random(20, entry);
    run_check("R10 start while busy", entry, POOL, 80, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule